// File: doc/BRIEF.md
# Fetch-to-Retire Instruction Match Queue

When a pipelined core runs in lockstep with a reference model, the core may fetch well ahead of the point the model has reached. Some of those fetches are later squashed by jumps, traps or flushes. This block records every fetch the core makes, as a pair of program counter and instruction word, in a first-in first-out ring. When the reference model wants its next instruction, it asks the block with the PC it is about to execute and the word it expects there.

The block serves such a request by walking the ring from its oldest entry, one entry per clock. Each entry it looks at is removed. The walk ends on the first entry whose PC and word both equal the request, and that word is returned as a hit. If the ring runs dry first, the block answers with a miss and sets a sticky mismatch flag. A push into a full ring is dropped and sets a sticky overflow flag. Pushes keep being taken while a request is being served.

Top module: `fetch_match_queue`

## Requirements
- R1: After reset the ring is empty, both sticky flags are 0, `rsp_valid` is 0 and `req_ready` is 1. A request made straight after reset resolves as a miss one cycle after it is accepted.
- R2: Entries are kept in the order they were pushed. A request compares the oldest entry first, so a match on the oldest entry responds one cycle after acceptance.
- R3: A hit needs both the PC and the word to be equal. An entry that matches on PC only is treated as a non-match and is discarded.
- R4: Non-matching entries are removed from the head at one per clock. A request whose first match is at position k (0 = oldest) gets its response in the cycle after the (k+1)-th rising edge that follows acceptance, and `rsp_valid` stays low before that.
- R5: On a hit, `rsp_hit` is 1, `rsp_insn` carries the matched word, and the matched entry is removed.
- R6: If none of the n entries present matches, the response comes n+1 cycles after acceptance with `rsp_hit` = 0, the ring is left empty, and `mismatch` goes to 1 in the same cycle. It stays at 1 until clear or reset.
- R7: `rsp_valid` is a one-cycle pulse for each accepted request. `req_ready` is 0 from the cycle after acceptance until the response cycle, and it is 1 in the response cycle.
- R8: A push while the ring holds DEPTH entries and no entry is being removed in that cycle is dropped. It sets a sticky `overflow` flag, and the dropped pair can never be matched.
- R9: A push and a removal in the same cycle both take effect. This holds even when the ring is full, and it does not set `overflow`.
- R10: A one-cycle `clear` pulse returns both sticky flags to 0 and leaves the ring contents untouched.
- R11: When the same PC appears several times with different words, a request picks the oldest entry whose word also matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| clear | input | 1 | Synchronous clear of both sticky flags |
| push_valid | input | 1 | Core fetched an instruction this cycle |
| push_pc | input | PC_W | Fetch PC |
| push_insn | input | INSN_W | Word delivered for that PC |
| req_valid | input | 1 | Reference model requests its next instruction |
| req_pc | input | PC_W | PC the model will execute |
| req_insn | input | INSN_W | Word the model expects at that PC |
| req_ready | output | 1 | Block is idle and will accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | 1 = match found, 0 = ring ran dry |
| rsp_insn | output | INSN_W | Matched word (0 on a miss) |
| mismatch | output | 1 | Sticky: a request found no match |
| overflow | output | 1 | Sticky: a push was dropped into a full ring |

## Verification
The assertions assume that a request is only presented while `req_ready` is high. They also assume the request fields are sampled only on the accepting edge, so the block latches them and ignores later changes. Under that assumption, a pop always finds a non-empty ring and a response can never follow another response directly. The stimulus holds `req_valid` for exactly one cycle, and only while the block is idle. Pushes that overlap a walk happen only in a directed case where the match lies ahead of the new entry, so the expected latency and result stay fixed.

// File: rtl/fmq_pkg.sv
package fmq_pkg;

    typedef enum logic {
        SCAN_IDLE = 1'b0,
        SCAN_BUSY = 1'b1
    } scan_state_e;

    typedef struct packed {
        logic mismatch;
        logic overflow;
    } sticky_t;

endpackage

// File: rtl/fmq_ring.sv
module fmq_ring #(
    parameter int DEPTH  = 16,
    parameter int PC_W   = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [PC_W-1:0]   push_pc,
    input  logic [INSN_W-1:0] push_insn,
    input  logic              pop_en,
    output logic [PC_W-1:0]   head_pc,
    output logic [INSN_W-1:0] head_insn,
    output logic              empty,
    output logic              push_drop
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int ENT_W = PC_W + INSN_W;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] head;
        logic [AW-1:0] tail;
        logic [CW-1:0] count;
    } ring_t;

    ring_t ring_d, ring_q;
    logic [ENT_W-1:0] mem [DEPTH];

    logic full;
    logic do_pop;
    logic do_push;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST_IDX) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ring_d    = ring_q;
        full      = (ring_q.count == FULL_CNT);
        empty     = (ring_q.count == '0);
        do_pop    = pop_en && !empty;
        do_push   = push_en && (!full || do_pop);
        push_drop = push_en && !do_push;

        if (do_pop) begin
            ring_d.head = bump(ring_q.head);
        end
        if (do_push) begin
            ring_d.tail = bump(ring_q.tail);
        end
        unique case ({do_push, do_pop})
            2'b10:   ring_d.count = ring_q.count + CW'(1);
            2'b01:   ring_d.count = ring_q.count - CW'(1);
            default: ring_d.count = ring_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[ring_q.tail] <= {push_pc, push_insn};
        end
    end

    assign {head_pc, head_insn} = mem[ring_q.head];

    // R8: occupancy never exceeds the configured depth
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ring_q.count <= FULL_CNT);

    // R8: a push is only lost when the ring is full and nothing leaves
    p_drop_only_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_drop |-> (full && !pop_en));

    // R9: push with a concurrent removal on a full ring keeps it full
    p_full_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push_en && pop_en) |=> (ring_q.count == FULL_CNT));

    // R6: the walker never removes from an empty ring
    p_pop_nonempty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pop_en |-> !empty);

endmodule

// File: rtl/fmq_scan.sv
module fmq_scan
    import fmq_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [INSN_W-1:0] req_insn,
    output logic              req_ready,
    input  logic              q_empty,
    input  logic [PC_W-1:0]   head_pc,
    input  logic [INSN_W-1:0] head_insn,
    output logic              pop_en,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [INSN_W-1:0] rsp_insn,
    output logic              miss_evt
);
    typedef struct packed {
        scan_state_e       st;
        logic [PC_W-1:0]   pc;
        logic [INSN_W-1:0] insn;
        logic              rsp_valid;
        logic              rsp_hit;
        logic [INSN_W-1:0] rsp_insn;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  head_match;

    always_comb begin
        scan_d           = scan_q;
        scan_d.rsp_valid = 1'b0;
        scan_d.rsp_hit   = 1'b0;
        pop_en           = 1'b0;
        miss_evt         = 1'b0;
        head_match       = (head_pc == scan_q.pc) && (head_insn == scan_q.insn);

        unique case (scan_q.st)
            SCAN_IDLE: begin
                if (req_valid) begin
                    scan_d.st   = SCAN_BUSY;
                    scan_d.pc   = req_pc;
                    scan_d.insn = req_insn;
                end
            end
            SCAN_BUSY: begin
                if (q_empty) begin
                    scan_d.st        = SCAN_IDLE;
                    scan_d.rsp_valid = 1'b1;
                    scan_d.rsp_insn  = '0;
                    miss_evt         = 1'b1;
                end else begin
                    pop_en = 1'b1;
                    if (head_match) begin
                        scan_d.st        = SCAN_IDLE;
                        scan_d.rsp_valid = 1'b1;
                        scan_d.rsp_hit   = 1'b1;
                        scan_d.rsp_insn  = head_insn;
                    end
                end
            end
            default: scan_d.st = SCAN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scan_q    <= '0;
            scan_q.st <= SCAN_IDLE;
        end else begin
            scan_q <= scan_d;
        end
    end

    assign req_ready = (scan_q.st == SCAN_IDLE);
    assign rsp_valid = scan_q.rsp_valid;
    assign rsp_hit   = scan_q.rsp_hit;
    assign rsp_insn  = scan_q.rsp_insn;

    // R7: a response strobe lasts exactly one cycle
    p_rsp_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7: an accepted request makes the block busy on the next cycle
    p_accept_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3: a full PC-and-word match on the head yields a hit with that word
    p_hit_on_match_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_ready && !q_empty && head_pc == scan_q.pc && head_insn == scan_q.insn)
        |=> (rsp_valid && rsp_hit && rsp_insn == $past(head_insn)));

    // R6: a miss is only reported once the ring has run dry
    p_miss_when_dry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> $past(q_empty));

endmodule

// File: rtl/fetch_match_queue.sv
module fetch_match_queue
    import fmq_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int PC_W   = 32,
    parameter int INSN_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              push_valid,
    input  logic [PC_W-1:0]   push_pc,
    input  logic [INSN_W-1:0] push_insn,
    input  logic              req_valid,
    input  logic [PC_W-1:0]   req_pc,
    input  logic [INSN_W-1:0] req_insn,
    output logic              req_ready,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [INSN_W-1:0] rsp_insn,
    output logic              mismatch,
    output logic              overflow
);
    logic              pop_en;
    logic              q_empty;
    logic              push_drop;
    logic              miss_evt;
    logic [PC_W-1:0]   head_pc;
    logic [INSN_W-1:0] head_insn;

    sticky_t flags_d, flags_q;

    fmq_ring #(
        .DEPTH  (DEPTH),
        .PC_W   (PC_W),
        .INSN_W (INSN_W)
    ) u_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .push_en   (push_valid),
        .push_pc   (push_pc),
        .push_insn (push_insn),
        .pop_en    (pop_en),
        .head_pc   (head_pc),
        .head_insn (head_insn),
        .empty     (q_empty),
        .push_drop (push_drop)
    );

    fmq_scan #(
        .PC_W   (PC_W),
        .INSN_W (INSN_W)
    ) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_pc    (req_pc),
        .req_insn  (req_insn),
        .req_ready (req_ready),
        .q_empty   (q_empty),
        .head_pc   (head_pc),
        .head_insn (head_insn),
        .pop_en    (pop_en),
        .rsp_valid (rsp_valid),
        .rsp_hit   (rsp_hit),
        .rsp_insn  (rsp_insn),
        .miss_evt  (miss_evt)
    );

    always_comb begin
        flags_d          = flags_q;
        flags_d.mismatch = (flags_q.mismatch && !clear) || miss_evt;
        flags_d.overflow = (flags_q.overflow && !clear) || push_drop;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

    assign mismatch = flags_q.mismatch;
    assign overflow = flags_q.overflow;

    // R6: mismatch stays set without a clear
    p_mismatch_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch && !clear) |=> mismatch);

    // R6: every miss response is accompanied by the sticky flag
    p_miss_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> mismatch);

    // R8: overflow stays set without a clear
    p_overflow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !clear) |=> overflow);

    // R10: a clear with no new event empties both flags
    p_clear_flags_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !miss_evt && !push_drop) |=> (!mismatch && !overflow));

endmodule

// File: tb/fetch_match_queue_tb.sv
module fetch_match_queue_tb;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear = 1'b0;
    logic        push_valid = 1'b0;
    logic [31:0] push_pc = '0;
    logic [31:0] push_insn = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic [31:0] req_insn = '0;
    logic        req_ready;
    logic        rsp_valid;
    logic        rsp_hit;
    logic [31:0] rsp_insn;
    logic        mismatch;
    logic        overflow;

    int  total = 0;
    int  bad = 0;
    bit  finished = 1'b0;
    bit  exp_mis = 1'b0;
    bit  exp_ovf = 1'b0;
    logic [63:0] mq[$];

    always #4ns clk = ~clk;

    fetch_match_queue #(.DEPTH(DEPTH), .PC_W(32), .INSN_W(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear(clear),
        .push_valid(push_valid), .push_pc(push_pc), .push_insn(push_insn),
        .req_valid(req_valid), .req_pc(req_pc), .req_insn(req_insn),
        .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_insn(rsp_insn), .mismatch(mismatch), .overflow(overflow)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic int find_idx(input logic [31:0] pc, input logic [31:0] ins);
        for (int i = 0; i < mq.size(); i++) begin
            if (mq[i] == {pc, ins}) return i;
        end
        return -1;
    endfunction

    task automatic report();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic do_push(input logic [31:0] pc, input logic [31:0] ins);
        @(negedge clk);
        push_valid = 1'b1; push_pc = pc; push_insn = ins;
        @(posedge clk);
        @(negedge clk);
        push_valid = 1'b0;
        if (mq.size() < DEPTH) mq.push_back({pc, ins});
        else exp_ovf = 1'b1;
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear = 1'b0;
        exp_mis = 1'b0;
        exp_ovf = 1'b0;
    endtask

    task automatic lookup(input logic [31:0] pc, input logic [31:0] ins,
                          input bit conc, input logic [31:0] cpc, input logic [31:0] cins);
        int  k;
        int  expc;
        int  early;
        bit  hit_exp;
        k = find_idx(pc, ins);
        hit_exp = (k >= 0);
        expc = hit_exp ? k + 1 : mq.size() + 1;
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_insn = ins;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        if (conc) begin
            push_valid = 1'b1; push_pc = cpc; push_insn = cins;
        end
        early = 0;
        for (int c = 1; c <= expc; c++) begin
            @(posedge clk);
            @(negedge clk);
            if (conc && c == 1) push_valid = 1'b0;
            if (c < expc && (rsp_valid || req_ready)) early++;
        end
        chk("R4 early response or ready", 64'(early), 64'd0);
        chk("R4 response strobe at scan latency", 64'(rsp_valid), 64'd1);
        chk("R3 hit versus miss", 64'(rsp_hit), 64'(hit_exp));
        if (hit_exp) chk("R5 returned word", 64'(rsp_insn), 64'(ins));
        chk("R7 ready in response cycle", 64'(req_ready), 64'd1);
        if (hit_exp) begin
            for (int j = 0; j <= k; j++) void'(mq.pop_front());
        end else begin
            mq.delete();
            exp_mis = 1'b1;
        end
        if (conc) mq.push_back({cpc, cins});
        chk("R6 sticky mismatch", 64'(mismatch), 64'(exp_mis));
        @(posedge clk);
        @(negedge clk);
        chk("R7 strobe is one cycle", 64'(rsp_valid), 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog act=running exp=finished");
            report();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        chk("R1 ready after reset", 64'(req_ready), 64'd1);
        chk("R1 no response after reset", 64'(rsp_valid), 64'd0);
        chk("R1 mismatch clear", 64'(mismatch), 64'd0);
        chk("R1 overflow clear", 64'(overflow), 64'd0);
        lookup(32'h100, 32'hAAAA0001, 1'b0, '0, '0);   // R1: empty ring misses in one cycle

        // R10: clear flags
        do_clear();
        chk("R10 mismatch cleared", 64'(mismatch), 64'd0);

        // R2: oldest entry first
        do_push(32'h20, 32'h11110000);
        do_push(32'h24, 32'h22220000);
        lookup(32'h20, 32'h11110000, 1'b0, '0, '0);
        lookup(32'h24, 32'h22220000, 1'b0, '0, '0);

        // R11 / R3: duplicated PC after a backward jump
        do_push(32'h10, 32'hA0000000);
        do_push(32'h14, 32'hB0000000);
        do_push(32'h10, 32'hC0000000);
        lookup(32'h10, 32'hC0000000, 1'b0, '0, '0);
        lookup(32'h14, 32'hB0000000, 1'b0, '0, '0);   // R4: discarded entry now misses
        do_clear();

        // R9: push while full and popping
        for (int i = 0; i < DEPTH; i++) do_push(32'h400 + 32'(i * 4), 32'h5000 + 32'(i));
        lookup(32'h40C, 32'h5003, 1'b1, 32'h800, 32'h9999);
        chk("R9 no overflow on full swap", 64'(overflow), 64'd0);
        lookup(32'h800, 32'h9999, 1'b0, '0, '0);
        lookup(32'h804, 32'h1, 1'b0, '0, '0);

        // R8: push into full ring is dropped
        do_clear();
        for (int i = 0; i < DEPTH; i++) do_push(32'h600 + 32'(i * 4), 32'h7000 + 32'(i));
        chk("R8 full without overflow", 64'(overflow), 64'd0);
        do_push(32'h900, 32'hDEAD);
        chk("R8 overflow sticky", 64'(overflow), 64'(exp_ovf));
        lookup(32'h900, 32'hDEAD, 1'b0, '0, '0);
        chk("R8 overflow held", 64'(overflow), 64'd1);

        // R10: clear keeps contents
        do_clear();
        do_push(32'h30, 32'h3030);
        do_clear();
        chk("R10 overflow cleared", 64'(overflow), 64'd0);
        lookup(32'h30, 32'h3030, 1'b0, '0, '0);

        // random rounds with colliding PCs
        for (int r = 0; r < 60; r++) begin
            int n;
            n = int'($urandom_range(6));
            for (int p = 0; p < n; p++) begin
                if (mq.size() < DEPTH)
                    do_push(32'($urandom_range(7)) * 4, 32'h100 + 32'($urandom_range(3)));
            end
            if (mq.size() > 0 && $urandom_range(9) < 7) begin
                int idx;
                idx = int'($urandom_range(mq.size() - 1));
                lookup(mq[idx][63:32], mq[idx][31:0], 1'b0, '0, '0);
            end else begin
                lookup(32'($urandom_range(7)) * 4, 32'h100 + 32'($urandom_range(4)), 1'b0, '0, '0);
            end
            if ($urandom_range(3) == 0) begin
                do_clear();
                chk("R10 random clear", 64'({mismatch, overflow}), 64'd0);
            end
        end

        finished = 1'b1;
        report();
    end
endmodule